// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block picks the divider settings for a phase-locked loop from a requested output frequency. Given a reference frequency and a requested output frequency, both in whole MHz, it searches for a pre-divider M, a feedback multiplier N and a post-divider table index PL whose output comes closest to the request. The PLL produces ref*N/M at its oscillator and divides that by the post-divide value. The block works on twice the requested frequency throughout. The reported error is the distance from that doubled value.

A start pulse captures both inputs and begins the search. The engine tries one candidate at a time and uses a single shared iterative divider for every quotient. When the search is finished it raises a valid flag. It then holds M, N, PL and the error until the next accepted start. A second flag reports that no candidate fell inside the limits. Every divider and frequency limit is a parameter.

Top module: `pll_coef_search`

## Requirements
- R1: The working target T is twice the request. The margin target G is T + floor(T/50). The upper oscillator limit is the larger of 2064 and G, so a request with G above 2064 can be met by an oscillator frequency above 2064.
- R2: Post-divide values by index 0..14 are 1,2,3,4,5,6,8,10,12,16,12,16,20,24,32. The upper bound is ceil(vmax/G) and the lower bound is floor(1000/G), each clamped to 1..32. Each bound becomes the first index among 0..13 whose value is at least the bound, or 14 if none qualifies. PL runs from the lower index up to the upper index.
- R3: For each PL, M runs upward from 1. An M with floor(ref/M) below 12 ends the M loop for that PL. An M with floor(ref/M) above 38 is skipped.
- R4: For each M, N is tried from floor(T*div*M/ref) up to that value rounded up. If the floor exceeds 255, the M loop for that PL ends. An N below 8 is skipped, and an N above 255 ends the N loop.
- R5: A candidate is accepted only when its oscillator frequency floor(ref*N/M) lies in [1000, vmax]. Its output is round(vco/div), computed as (vco + floor(div/2))/div, and its error is |output - T|. Only a strictly smaller error replaces the held best result, so among equal errors the first one found is kept.
- R6: The search stops as soon as a candidate with zero error is found.
- R7: Before any candidate is accepted, the best result is M=255, N=8, PL=1 with error all-ones (16383). If that error is still all-ones at the end, the no-candidate flag rises together with valid.
- R8: Valid drops at an accepted start and rises when the search ends. Results then stay fixed until the next start. A start pulse during a search is ignored.
- R9: After reset, valid and the no-candidate flag are low and the outputs show the default result of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that starts a search when idle |
| ref_mhz | input | REF_W (8) | Reference frequency in MHz |
| req_mhz | input | REQ_W (12) | Requested output frequency in MHz |
| m_o | output | M_W (8) | Best pre-divider M |
| n_o | output | N_W (8) | Best feedback multiplier N |
| pl_o | output | 4 | Best post-divider table index |
| err_o | output | REQ_W+2 (14) | Best absolute error against the doubled request |
| valid_o | output | 1 | Search finished and results held |
| nocand_o | output | 1 | No candidate satisfied the limits |

## Verification
The assertions check on every cycle that the results stay frozen while valid is high and no start arrives. They also check that the best error never grows during a search, that the no-candidate flag only appears with valid and with the default triple, and that a valid result has M, N and PL inside their limits. The bench scenarios are the only way to show that the chosen triple is the correct one. They cover the non-monotonic table lookup, the raised oscillator ceiling, the tie rule, the early stop (seen as shorter latency), and a start ignored during a search.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_MARG, ST_HI, ST_LO, ST_PLSET, ST_MCHK,
    ST_NDIV, ST_NCHK, ST_VDIV, ST_LDIV, ST_DONE
  } pcs_state_e;

  localparam int PL_LAST  = 14;   // highest table index
  localparam int PL_SCAN  = 14;   // indices scanned when mapping a bound
  localparam int PLD_W    = 6;    // width of a post-divide value

  // post-divide value for each table index (non-monotonic on purpose)
  function automatic logic [PLD_W-1:0] pl_div(input logic [3:0] idx);
    case (idx)
      4'd0:    return 6'd1;
      4'd1:    return 6'd2;
      4'd2:    return 6'd3;
      4'd3:    return 6'd4;
      4'd4:    return 6'd5;
      4'd5:    return 6'd6;
      4'd6:    return 6'd8;
      4'd7:    return 6'd10;
      4'd8:    return 6'd12;
      4'd9:    return 6'd16;
      4'd10:   return 6'd12;
      4'd11:   return 6'd16;
      4'd12:   return 6'd20;
      4'd13:   return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/pcs_div.sv
// Restoring divider, one quotient bit per clock.
module pcs_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  den_r;
  logic [CW-1:0] cnt;
  logic [W:0]    trial;

  assign trial = {rem, quo[W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      quo   <= '0;
      rem   <= '0;
      den_r <= '0;
      cnt   <= '0;
      done  <= 1'b0;
    end else if (go) begin
      quo   <= num;
      rem   <= '0;
      den_r <= den;
      cnt   <= CW'(W);
      done  <= 1'b0;
    end else if (cnt != '0) begin
      if (trial >= {1'b0, den_r}) begin
        rem <= W'(trial - {1'b0, den_r});
        quo <= {quo[W-2:0], 1'b1};
      end else begin
        rem <= trial[W-1:0];
        quo <= {quo[W-2:0], 1'b0};
      end
      cnt  <= cnt - 1'b1;
      done <= (cnt == CW'(1));
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/pcs_pl_index.sv
// Maps a post-divide bound to the first table index whose value reaches it.
module pcs_pl_index
  import pcs_pkg::*;
(
  input  logic [PLD_W-1:0] bound,
  output logic [3:0]       idx
);
  always_comb begin
    logic found;
    found = 1'b0;
    idx   = 4'(PL_LAST);
    for (int i = 0; i < PL_SCAN; i++) begin
      if (!found && pl_div(4'(i)) >= bound) begin
        idx   = 4'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
  import pcs_pkg::*;
#(
  parameter int REF_W      = 8,
  parameter int REQ_W      = 12,
  parameter int M_W        = 8,
  parameter int N_W        = 8,
  parameter int DW         = 32,
  parameter int VCO_MIN    = 1000,
  parameter int VCO_MAX    = 2064,
  parameter int U_MIN      = 12,
  parameter int U_MAX      = 38,
  parameter int M_MIN      = 1,
  parameter int M_MAX      = 255,
  parameter int N_MIN      = 8,
  parameter int N_MAX      = 255,
  parameter int DIV_MIN    = 1,
  parameter int DIV_MAX    = 32,
  parameter int MARGIN_DEN = 50
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [REF_W-1:0]   ref_mhz,
  input  logic [REQ_W-1:0]   req_mhz,
  output logic [M_W-1:0]     m_o,
  output logic [N_W-1:0]     n_o,
  output logic [3:0]         pl_o,
  output logic [REQ_W+1:0]   err_o,
  output logic               valid_o,
  output logic               nocand_o
);
  localparam int ERR_W = REQ_W + 2;
  localparam logic [ERR_W-1:0] ERR_NONE = '1;
  localparam logic [DW-1:0] VMIN_W = DW'(VCO_MIN);
  localparam logic [DW-1:0] VMAX_W = DW'(VCO_MAX);
  localparam logic [DW-1:0] UMIN_W = DW'(U_MIN);
  localparam logic [DW-1:0] UOVR_W = DW'(U_MAX + 1);
  localparam logic [DW-1:0] NMIN_W = DW'(N_MIN);
  localparam logic [DW-1:0] NMAX_W = DW'(N_MAX);
  localparam logic [DW-1:0] DMIN_W = DW'(DIV_MIN);
  localparam logic [DW-1:0] DMAX_W = DW'(DIV_MAX);

  pcs_state_e        state;
  logic [DW-1:0]     ref_r, tgt2, vmax, vt, n_r, n_hi;
  logic [PLD_W-1:0]  dv;
  logic [3:0]        pl, hi_idx;
  logic [M_W-1:0]    m_r;

  logic              dv_go, dv_done;
  logic [DW-1:0]     dv_a, dv_b, dv_q, dv_r;

  // shared divider
  pcs_div #(.W(DW)) u_div (
    .clk(clk), .rst(rst), .go(dv_go), .num(dv_a), .den(dv_b),
    .quo(dv_q), .rem(dv_r), .done(dv_done)
  );

  // combinational helpers on the divider result
  logic [DW-1:0]    mg_sum, vmax_c, ceil_q, bound_raw, diff;
  logic [PLD_W-1:0] bound_c;
  logic [3:0]       idx_c;
  logic [DW-1:0]    m_w;
  logic             err_better, in_win;

  assign m_w    = DW'(m_r);
  assign mg_sum = tgt2 + dv_q;
  assign vmax_c = (mg_sum > VMAX_W) ? mg_sum : VMAX_W;
  assign ceil_q = dv_q + DW'(dv_r != '0);
  assign bound_raw = (state == ST_HI) ? ceil_q : dv_q;

  always_comb begin
    if (bound_raw < DMIN_W)      bound_c = PLD_W'(DIV_MIN);
    else if (bound_raw > DMAX_W) bound_c = PLD_W'(DIV_MAX);
    else                         bound_c = bound_raw[PLD_W-1:0];
  end

  pcs_pl_index u_idx (.bound(bound_c), .idx(idx_c));

  assign diff       = (dv_q >= tgt2) ? (dv_q - tgt2) : (tgt2 - dv_q);
  assign err_better = diff < DW'(err_o);
  assign in_win     = (dv_q >= VMIN_W) && (dv_q <= vmax);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ref_r    <= '0;
      tgt2     <= '0;
      vmax     <= '0;
      vt       <= '0;
      n_r      <= '0;
      n_hi     <= '0;
      dv       <= '0;
      pl       <= '0;
      hi_idx   <= '0;
      m_r      <= '0;
      dv_go    <= 1'b0;
      dv_a     <= '0;
      dv_b     <= '0;
      m_o      <= M_W'(M_MAX);
      n_o      <= N_W'(N_MIN);
      pl_o     <= 4'(DIV_MIN);
      err_o    <= ERR_NONE;
      valid_o  <= 1'b0;
      nocand_o <= 1'b0;
    end else begin
      dv_go <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          ref_r    <= DW'(ref_mhz);
          tgt2     <= DW'(req_mhz) << 1;
          dv_go    <= 1'b1;
          dv_a     <= DW'(req_mhz) << 1;
          dv_b     <= DW'(MARGIN_DEN);
          m_o      <= M_W'(M_MAX);
          n_o      <= N_W'(N_MIN);
          pl_o     <= 4'(DIV_MIN);
          err_o    <= ERR_NONE;
          valid_o  <= 1'b0;
          nocand_o <= 1'b0;
          state    <= ST_MARG;
        end
        ST_MARG: if (dv_done) begin
          vmax  <= vmax_c;
          dv_go <= 1'b1;
          dv_a  <= vmax_c;
          dv_b  <= mg_sum;
          state <= ST_HI;
        end
        ST_HI: if (dv_done) begin
          hi_idx <= idx_c;
          dv_go  <= 1'b1;
          dv_a   <= VMIN_W;
          dv_b   <= dv_b;          // margin target still held
          state  <= ST_LO;
        end
        ST_LO: if (dv_done) begin
          pl    <= idx_c;
          state <= ST_PLSET;
        end
        ST_PLSET: begin
          if (pl > hi_idx) begin
            state <= ST_DONE;
          end else begin
            dv    <= pl_div(pl);
            vt    <= tgt2 * DW'(pl_div(pl));
            m_r   <= M_W'(M_MIN);
            state <= ST_MCHK;
          end
        end
        ST_MCHK: begin
          if (ref_r < UMIN_W * m_w) begin
            pl    <= pl + 1'b1;
            state <= ST_PLSET;
          end else if (ref_r >= UOVR_W * m_w) begin
            if (m_r == M_W'(M_MAX)) begin
              pl    <= pl + 1'b1;
              state <= ST_PLSET;
            end else begin
              m_r   <= m_r + 1'b1;
            end
          end else begin
            dv_go <= 1'b1;
            dv_a  <= vt * m_w;
            dv_b  <= ref_r;
            state <= ST_NDIV;
          end
        end
        ST_NDIV: if (dv_done) begin
          if (dv_q > NMAX_W) begin
            pl    <= pl + 1'b1;
            state <= ST_PLSET;
          end else begin
            n_r   <= dv_q;
            n_hi  <= ceil_q;
            state <= ST_NCHK;
          end
        end
        ST_NCHK: begin
          if (n_r > n_hi || n_r > NMAX_W) begin
            if (m_r == M_W'(M_MAX)) begin
              pl    <= pl + 1'b1;
              state <= ST_PLSET;
            end else begin
              m_r   <= m_r + 1'b1;
              state <= ST_MCHK;
            end
          end else if (n_r < NMIN_W) begin
            n_r <= n_r + 1'b1;
          end else begin
            dv_go <= 1'b1;
            dv_a  <= ref_r * n_r;
            dv_b  <= m_w;
            state <= ST_VDIV;
          end
        end
        ST_VDIV: if (dv_done) begin
          if (in_win) begin
            dv_go <= 1'b1;
            dv_a  <= dv_q + DW'(dv >> 1);
            dv_b  <= DW'(dv);
            state <= ST_LDIV;
          end else begin
            n_r   <= n_r + 1'b1;
            state <= ST_NCHK;
          end
        end
        ST_LDIV: if (dv_done) begin
          if (err_better) begin
            m_o   <= m_r;
            n_o   <= n_r[N_W-1:0];
            pl_o  <= pl;
            err_o <= diff[ERR_W-1:0];
          end
          if (diff == '0) begin
            state <= ST_DONE;
          end else begin
            n_r   <= n_r + 1'b1;
            state <= ST_NCHK;
          end
        end
        ST_DONE: begin
          valid_o  <= 1'b1;
          nocand_o <= (err_o == ERR_NONE);
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_coef_search_chk.sv
module pll_coef_search_chk #(
  parameter int M_W     = 8,
  parameter int N_W     = 8,
  parameter int ERR_W   = 14,
  parameter int M_MIN   = 1,
  parameter int M_MAX   = 255,
  parameter int N_MIN   = 8,
  parameter int N_MAX   = 255,
  parameter int DIV_MIN = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [M_W-1:0]   m_o,
  input logic [N_W-1:0]   n_o,
  input logic [3:0]       pl_o,
  input logic [ERR_W-1:0] err_o,
  input logic             valid_o,
  input logic             nocand_o
);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !start) |=> (valid_o && $stable(m_o) && $stable(n_o)
                             && $stable(pl_o) && $stable(err_o)));

  a_r8_fall_on_start: assert property (@(posedge clk) disable iff (rst)
    $fell(valid_o) |-> $past(start));

  a_r5_err_nonincr: assert property (@(posedge clk) disable iff (rst)
    !start |=> (err_o <= $past(err_o)));

  a_r7_nocand_default: assert property (@(posedge clk) disable iff (rst)
    nocand_o |-> (valid_o && m_o == M_W'(M_MAX) && n_o == N_W'(N_MIN)
                  && pl_o == 4'(DIV_MIN) && err_o == '1));

  a_r2_pl_range: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (pl_o <= 4'd14));

  a_r3_m_range: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !nocand_o) |-> (m_o >= M_W'(M_MIN) && m_o <= M_W'(M_MAX)));

  a_r4_n_range: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !nocand_o) |-> (n_o >= N_W'(N_MIN) && n_o <= N_W'(N_MAX)));
endmodule

bind pll_coef_search pll_coef_search_chk #(
  .M_W(M_W), .N_W(N_W), .ERR_W(REQ_W + 2), .M_MIN(M_MIN), .M_MAX(M_MAX),
  .N_MIN(N_MIN), .N_MAX(N_MAX), .DIV_MIN(DIV_MIN)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .m_o(m_o), .n_o(n_o), .pl_o(pl_o),
  .err_o(err_o), .valid_o(valid_o), .nocand_o(nocand_o)
);

// File: tb/pll_coef_search_tb.sv
module pll_coef_search_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  ref_mhz = '0;
  logic [11:0] req_mhz = '0;
  logic [7:0]  m_o, n_o;
  logic [3:0]  pl_o;
  logic [13:0] err_o;
  logic        valid_o, nocand_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pll_coef_search u_dut (
    .clk(clk), .rst(rst), .start(start), .ref_mhz(ref_mhz), .req_mhz(req_mhz),
    .m_o(m_o), .n_o(n_o), .pl_o(pl_o), .err_o(err_o),
    .valid_o(valid_o), .nocand_o(nocand_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int tdiv(input int i);
    case (i)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;  4: return 5;
      5: return 6;  6: return 8;  7: return 10; 8: return 12; 9: return 16;
      10: return 12; 11: return 16; 12: return 20; 13: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic int first_idx(input int b);
    for (int i = 0; i < 14; i++) if (tdiv(i) >= b) return i;
    return 14;
  endfunction

  function automatic int clampd(input int b);
    return (b < 1) ? 1 : ((b > 32) ? 32 : b);
  endfunction

  // independent model of the requirements
  task automatic model(input int rf, input int rq, output int om, output int on,
                       output int opl, output int oerr, output int onc);
    int t2, mg, vmx, li, hi, best;
    bit fin;
    t2 = rq * 2; mg = t2 + t2 / 50;
    vmx = (mg > 2064) ? mg : 2064;
    hi = first_idx(clampd((vmx + mg - 1) / mg));
    li = first_idx(clampd(1000 / mg));
    best = 16383; om = 255; on = 8; opl = 1; fin = 0;
    for (int pl = li; pl <= hi && !fin; pl++) begin
      int d, vt;
      d = tdiv(pl); vt = t2 * d;
      for (int m = 1; m <= 255 && !fin; m++) begin
        int nf, nc;
        if (rf < 12 * m) break;
        if (rf >= 39 * m) continue;
        nf = vt * m / rf; nc = (vt * m + rf - 1) / rf;
        if (nf > 255) break;
        for (int n = nf; n <= nc && !fin; n++) begin
          int v, l, dl;
          if (n < 8) continue;
          if (n > 255) break;
          v = rf * n / m;
          if (v >= 1000 && v <= vmx) begin
            l = (v + d / 2) / d;
            dl = (l > t2) ? l - t2 : t2 - l;
            if (dl < best) begin best = dl; om = m; on = n; opl = pl; end
            if (dl == 0) fin = 1;
          end
        end
      end
    end
    oerr = best; onc = (best == 16383) ? 1 : 0;
  endtask

  task automatic run(input int rf, input int rq, output int lat);
    int c0;
    @(negedge clk);
    ref_mhz = 8'(rf); req_mhz = 12'(rq); start = 1'b1;
    c0 = cyc;
    @(negedge clk);
    start = 1'b0;
    while (!valid_o) @(negedge clk);
    lat = cyc - c0;
  endtask

  task automatic cmp_model(input string req, input int rf, input int rq);
    int em, en, ep, ee, ec;
    model(rf, rq, em, en, ep, ee, ec);
    chk(req, "M", int'(m_o), em);
    chk(req, "N", int'(n_o), en);
    chk(req, "PL", int'(pl_o), ep);
    chk(req, "err", int'(err_o), ee);
    chk(req, "nocand", int'(nocand_o), ec);
  endtask

  task automatic t_reset;
    chk("R9", "valid", int'(valid_o), 0);
    chk("R9", "nocand", int'(nocand_o), 0);
    chk("R9", "M", int'(m_o), 255);
    chk("R9", "N", int'(n_o), 8);
    chk("R9", "PL", int'(pl_o), 1);
    chk("R9", "err", int'(err_o), 16383);
  endtask

  // ref 38, request 500: exact at M=3 N=79 PL=0 (R3, R4, R5, R6)
  task automatic t_exact(output int lat);
    run(38, 500, lat);
    chk("R6", "M", int'(m_o), 3);
    chk("R4", "N", int'(n_o), 79);
    chk("R3", "PL", int'(pl_o), 0);
    chk("R5", "err", int'(err_o), 0);
  endtask

  // ref 38, request 1500: raised ceiling, tie keeps M=1 N=79 err 2
  task automatic t_raise;
    int lat;
    run(38, 1500, lat);
    chk("R1", "M", int'(m_o), 1);
    chk("R1", "N", int'(n_o), 79);
    chk("R5", "PL", int'(pl_o), 0);
    chk("R5", "err", int'(err_o), 2);
    chk("R1", "nocand", int'(nocand_o), 0);
  endtask

  // ref 10 below the phase-detector floor: defaults and flag
  task automatic t_nocand;
    int lat;
    run(10, 400, lat);
    chk("R7", "nocand", int'(nocand_o), 1);
    chk("R7", "M", int'(m_o), 255);
    chk("R7", "N", int'(n_o), 8);
    chk("R7", "PL", int'(pl_o), 1);
    chk("R7", "err", int'(err_o), 16383);
  endtask

  task automatic t_sweep;
    int lat;
    run(38, 501, lat); cmp_model("R5", 38, 501);
    run(26, 300, lat); cmp_model("R4", 26, 300);
    run(20, 750, lat); cmp_model("R3", 20, 750);
    run(13, 100, lat); cmp_model("R2", 13, 100);
    run(30, 1000, lat); cmp_model("R1", 30, 1000);
    run(17, 250, lat); cmp_model("R5", 17, 250);
  endtask

  // request 39: lower bound 12 maps to index 8, upper bound 27 saturates to 14
  task automatic t_index;
    int lat;
    run(38, 39, lat);
    cmp_model("R2", 38, 39);
    chk("R2", "PL at least 8", int'(pl_o >= 4'd8), 1);
  endtask

  task automatic t_early(input int lat_exact);
    int lat_full;
    run(38, 501, lat_full);
    chk("R6", "early stop shorter", int'(lat_exact * 2 < lat_full), 1);
  endtask

  task automatic t_busy_start;
    @(negedge clk);
    ref_mhz = 8'd26; req_mhz = 12'd300; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    ref_mhz = 8'd10; req_mhz = 12'd400; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!valid_o) @(negedge clk);
    cmp_model("R8", 26, 300);
  endtask

  task automatic t_hold;
    int m0, n0, p0, e0;
    m0 = int'(m_o); n0 = int'(n_o); p0 = int'(pl_o); e0 = int'(err_o);
    ref_mhz = 8'd38; req_mhz = 12'd1500;
    repeat (60) @(negedge clk);
    chk("R8", "valid held", int'(valid_o), 1);
    chk("R8", "M held", int'(m_o), m0);
    chk("R8", "N held", int'(n_o), n0);
    chk("R8", "PL held", int'(pl_o), p0);
    chk("R8", "err held", int'(err_o), e0);
  endtask

  initial begin
    int lat_x;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_exact(lat_x);
    t_raise();
    t_nocand();
    t_sweep();
    t_index();
    t_early(lat_x);
    t_busy_start();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule